// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits behind the write port of a byte-wide parallel flash and turns streams of bus writes into operation requests. Each write is one address, one data byte and a write strobe. The strobe may arrive from another clock domain, so it is synchronised, and only its rising edge counts as a write. The decoder looks for the keyed unlock pair, a set-up command, and the further key pair and confirm that erase needs. When a sequence completes, it raises a one-cycle request towards the program/erase engine. The request carries the captured address and data.

A block erase does not start at once. The first block confirm opens a timed window. Each further block confirm inside that window adds a block and restarts the timer. When the timer runs out, the decoder issues the request that starts the erase. The block also reports which kind of data a read returns: array contents, identification data, or engine status.

While the engine is busy it gates commands: a running program accepts no command, and a running erase accepts only suspend. Any write that breaks a sequence sends the decoder back to read-array mode.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, read_mode is 0 (array) and op_valid is low.
- R2: The writes AAh@555h, 55h@AAAh, A0h@555h, then any data at any address give exactly one request with op_kind 1 (program). That request carries the fourth write's address and data.
- R3: Key and set-up writes compare only address bits 11..0. Bits 17..12 are ignored.
- R4: The writes AAh@555h, 55h@AAAh, 80h@555h, AAh@555h, 55h@AAAh, 10h@555h give exactly one request with op_kind 2 (chip erase).
- R5: The same five leading writes, followed by 30h at any address, give op_kind 3 (block mark) carrying that address. They also open a window. If no further block mark follows, op_kind 4 (erase start) appears exactly WIN_CYC+1 cycles after the last block mark.
- R6: A 30h write inside the window gives another block mark and restarts the window. This also holds when the write lands in the window's final cycle, where the add wins over expiry. A 30h write one cycle after expiry is not added.
- R7: A write with the wrong address or wrong data anywhere in a sequence returns the decoder to idle without a request. The next valid sequence then works.
- R8: The writes AAh@555h, 55h@AAAh, 90h@555h set read_mode to 1 (signature). The next write of any kind returns it to 0.
- R9: read_mode is 2 (status) while the erase window is open or the engine reports program or erase busy.
- R10: While an erase runs and is not suspended, a full program sequence produces no request. A B0h write at any address gives op_kind 5 (suspend).
- R11: While an erase is suspended, read_mode is 0. A program sequence is accepted. An erase set-up is rejected. A single 30h write gives op_kind 6 (resume).
- R12: A write strobe held high for many cycles counts as a single write, and each request lasts one cycle.
- R13: While a program runs, every write is ignored and no request appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up or undervoltage) |
| wr_strobe | input | 1 | Write strobe; one rising edge is one write |
| wr_addr | input | ADDR_W | Write address, held while the strobe is high |
| wr_data | input | 8 | Write data, held while the strobe is high |
| pe_prog_busy | input | 1 | Engine is programming |
| pe_erase_busy | input | 1 | Engine is erasing (low while suspended) |
| pe_suspended | input | 1 | An erase is suspended |
| op_valid | output | 1 | One-cycle request strobe |
| op_kind | output | 3 | 1 program, 2 chip erase, 3 block mark, 4 erase start, 5 suspend, 6 resume |
| op_addr | output | ADDR_W | Address captured with the request |
| op_data | output | 8 | Data captured with the request |
| read_mode | output | 2 | 0 array, 1 signature, 2 status |

## Verification
Window expiry and a late additional block address can both fall in the same cycle. The bench first records the cycle of the first block mark request. It then raises the strobe so that the synchronised edge is decoded exactly in the cycle where the window count reaches zero, and, in a second run, one cycle later. In the first run, the bench requires a second block mark with no erase start before it, then an erase start WIN_CYC+1 cycles after that mark. In the second run, the bench requires that the erase start keep its original time and that the late address add nothing.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    OP_NONE        = 3'd0,
    OP_PROGRAM     = 3'd1,
    OP_CHIP_ERASE  = 3'd2,
    OP_BLOCK_MARK  = 3'd3,
    OP_ERASE_START = 3'd4,
    OP_SUSPEND     = 3'd5,
    OP_RESUME      = 3'd6
  } op_kind_e;

  typedef enum logic [1:0] {
    RM_ARRAY     = 2'd0,
    RM_SIGNATURE = 2'd1,
    RM_STATUS    = 2'd2
  } rd_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_PROG, SQ_ERS3, SQ_ERS4, SQ_ERS5, SQ_WIN
  } seq_e;

  localparam int unsigned KEY_ADDR_W = 12;
  localparam logic [KEY_ADDR_W-1:0] ADDR_KEY_A = 12'h555;
  localparam logic [KEY_ADDR_W-1:0] ADDR_KEY_B = 12'hAAA;

  localparam logic [7:0] DAT_KEY_A   = 8'hAA;
  localparam logic [7:0] DAT_KEY_B   = 8'h55;
  localparam logic [7:0] DAT_PROG    = 8'hA0;
  localparam logic [7:0] DAT_ERASE   = 8'h80;
  localparam logic [7:0] DAT_IDENT   = 8'h90;
  localparam logic [7:0] DAT_RESET   = 8'hF0;
  localparam logic [7:0] DAT_CHIP    = 8'h10;
  localparam logic [7:0] DAT_BLOCK   = 8'h30;
  localparam logic [7:0] DAT_SUSPEND = 8'hB0;

  // A keyed write matches on the low address bits and the exact data byte.
  function automatic logic key_hit(input logic [KEY_ADDR_W-1:0] low_addr,
                                   input logic [KEY_ADDR_W-1:0] want_addr,
                                   input logic [7:0]            dat,
                                   input logic [7:0]            want_dat);
    return (low_addr == want_addr) && (dat == want_dat);
  endfunction

  // Status reads take priority over identification reads.
  function automatic rd_mode_e pick_mode(input logic engine_or_window, input logic ident);
    if (engine_or_window) return RM_STATUS;
    if (ident)            return RM_SIGNATURE;
    return RM_ARRAY;
  endfunction

endpackage

// File: rtl/fcs_strobe_sync.sv
module fcs_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic rise
);
  logic [STAGES:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-1:0], strobe_in};
  end

  assign rise = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/fcs_window_timer.sv
module fcs_window_timer #(
  parameter int unsigned WIN_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active,
  output logic expire
);
  localparam int unsigned CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      cnt_q <= CNT_LOAD;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = act_q;
  assign expire = act_q && (cnt_q == '0);
endmodule

// File: rtl/fcs_seq_fsm.sv
module fcs_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              prog_busy,
  input  logic              erase_busy,
  input  logic              suspended,
  input  logic              win_expire,
  output logic              win_load,
  output logic              ident_mode,
  output logic              op_valid,
  output op_kind_e          op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);
  seq_e     st_q, st_n;
  logic     ident_q, ident_n;
  op_kind_e op_n;
  logic [KEY_ADDR_W-1:0] low;

  assign low = addr[KEY_ADDR_W-1:0];

  always_comb begin
    st_n     = st_q;
    ident_n  = ident_q;
    op_n     = OP_NONE;
    win_load = 1'b0;
    if (st_q == SQ_WIN) begin
      if (evt && data == DAT_BLOCK) begin
        op_n     = OP_BLOCK_MARK;
        win_load = 1'b1;
      end else if (win_expire) begin
        op_n = OP_ERASE_START;
        st_n = SQ_IDLE;
      end
    end else if (evt) begin
      if (prog_busy) begin
        st_n = st_q;
      end else if (erase_busy) begin
        st_n    = SQ_IDLE;
        ident_n = 1'b0;
        if (data == DAT_SUSPEND) op_n = OP_SUSPEND;
      end else begin
        ident_n = 1'b0;
        st_n    = SQ_IDLE;
        unique case (st_q)
          SQ_IDLE: begin
            if (key_hit(low, ADDR_KEY_A, data, DAT_KEY_A)) st_n = SQ_KEY1;
            else if (suspended && data == DAT_BLOCK)       op_n = OP_RESUME;
          end
          SQ_KEY1: if (key_hit(low, ADDR_KEY_B, data, DAT_KEY_B)) st_n = SQ_KEY2;
          SQ_KEY2: begin
            if (key_hit(low, ADDR_KEY_A, data, DAT_PROG))                    st_n = SQ_PROG;
            else if (key_hit(low, ADDR_KEY_A, data, DAT_IDENT))              ident_n = 1'b1;
            else if (!suspended && key_hit(low, ADDR_KEY_A, data, DAT_ERASE)) st_n = SQ_ERS3;
          end
          SQ_PROG: op_n = OP_PROGRAM;
          SQ_ERS3: if (key_hit(low, ADDR_KEY_A, data, DAT_KEY_A)) st_n = SQ_ERS4;
          SQ_ERS4: if (key_hit(low, ADDR_KEY_B, data, DAT_KEY_B)) st_n = SQ_ERS5;
          SQ_ERS5: begin
            if (key_hit(low, ADDR_KEY_A, data, DAT_CHIP)) begin
              op_n = OP_CHIP_ERASE;
            end else if (data == DAT_BLOCK) begin
              op_n     = OP_BLOCK_MARK;
              win_load = 1'b1;
              st_n     = SQ_WIN;
            end
          end
          default: st_n = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      ident_q  <= 1'b0;
      op_valid <= 1'b0;
      op_kind  <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      st_q     <= st_n;
      ident_q  <= ident_n;
      op_valid <= (op_n != OP_NONE);
      op_kind  <= op_n;
      if (op_n != OP_NONE) begin
        op_addr <= addr;
        op_data <= data;
      end
    end
  end

  assign ident_mode = ident_q;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned WIN_CYC     = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              pe_prog_busy,
  input  logic              pe_erase_busy,
  input  logic              pe_suspended,
  output logic              op_valid,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic [1:0]        read_mode
);
  logic     wr_evt;
  logic     win_load;
  logic     win_active;
  logic     win_expire;
  logic     ident_mode;
  op_kind_e kind_w;

  fcs_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_in(wr_strobe), .rise(wr_evt)
  );

  fcs_window_timer #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .load(win_load), .active(win_active), .expire(win_expire)
  );

  fcs_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .evt(wr_evt), .addr(wr_addr), .data(wr_data),
    .prog_busy(pe_prog_busy), .erase_busy(pe_erase_busy), .suspended(pe_suspended),
    .win_expire(win_expire), .win_load(win_load), .ident_mode(ident_mode),
    .op_valid(op_valid), .op_kind(kind_w), .op_addr(op_addr), .op_data(op_data)
  );

  assign op_kind   = kind_w;
  assign read_mode = pick_mode(pe_prog_busy | pe_erase_busy | win_active, ident_mode);
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       evt,
  input logic       win_active,
  input logic       win_expire,
  input logic       pe_prog_busy,
  input logic       pe_erase_busy,
  input logic       pe_suspended,
  input logic       op_valid,
  input logic [2:0] op_kind
);
  AST_MARK_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd3) |-> win_active); // R5

  AST_START_CLOSES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd4) |-> ($past(win_active) && !win_active)); // R5

  AST_REQUEST_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(evt || win_expire)); // R12

  AST_ERASE_ONLY_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt && pe_erase_busy && !pe_suspended && !win_active) && op_valid) |-> op_kind == 3'd5); // R10

  AST_PROGRAM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt && pe_prog_busy && !win_active && !win_expire) |-> !op_valid); // R13
endmodule

bind flash_cmd_seq fcs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .evt(wr_evt), .win_active(win_active), .win_expire(win_expire),
  .pe_prog_busy(pe_prog_busy), .pe_erase_busy(pe_erase_busy), .pe_suspended(pe_suspended),
  .op_valid(op_valid), .op_kind(op_kind)
);

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;
  localparam int AW = 18;
  localparam int W = 24;
  localparam int PROG_LEN = 60;
  localparam int ERASE_LEN = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_strobe = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic pe_prog_busy = 1'b0, pe_erase_busy = 1'b0, pe_suspended = 1'b0;
  logic op_valid;
  logic [2:0] op_kind;
  logic [AW-1:0] op_addr;
  logic [7:0] op_data;
  logic [1:0] read_mode;

  int total = 0, fails = 0, cyc = 0, n_ops = 0;
  int pcnt = 0, ecnt = 0;
  logic [2:0] lk [0:63];
  logic [AW-1:0] la [0:63];
  logic [7:0] ld [0:63];
  int lt [0:63];

  always #5 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .WIN_CYC(W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
    .pe_prog_busy(pe_prog_busy), .pe_erase_busy(pe_erase_busy), .pe_suspended(pe_suspended),
    .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
    .read_mode(read_mode)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Request log and behavioural program/erase engine
  always @(negedge clk) begin
    if (rst_n) begin
      if (op_valid && n_ops < 64) begin
        lk[n_ops] = op_kind; la[n_ops] = op_addr; ld[n_ops] = op_data; lt[n_ops] = cyc;
        n_ops = n_ops + 1;
      end
      if (pe_prog_busy) begin
        if (pcnt == 0) pe_prog_busy <= 1'b0; else pcnt <= pcnt - 1;
      end
      if (pe_erase_busy) begin
        if (ecnt == 0) pe_erase_busy <= 1'b0; else ecnt <= ecnt - 1;
      end
      if (op_valid) begin
        case (op_kind)
          3'd1: begin pe_prog_busy <= 1'b1; pcnt <= PROG_LEN; end
          3'd2, 3'd4: begin pe_erase_busy <= 1'b1; ecnt <= ERASE_LEN; end
          3'd5: begin pe_erase_busy <= 1'b0; pe_suspended <= 1'b1; end
          3'd6: begin pe_erase_busy <= 1'b1; pe_suspended <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at a negedge.
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input int hold = 4);
    wr_addr = a; wr_data = d; wr_strobe = 1'b1;
    repeat (hold) @(negedge clk);
    wr_strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic unlock3(input logic [7:0] cmd);
    wr(18'h00555, 8'hAA); wr(18'h00AAA, 8'h55); wr(18'h00555, cmd);
  endtask

  task automatic block_erase(input logic [AW-1:0] blk);
    unlock3(8'h80); wr(18'h00555, 8'hAA); wr(18'h00AAA, 8'h55); wr(blk, 8'h30);
  endtask

  task automatic wait_ops(input int n);
    for (int i = 0; i < 3000 && n_ops < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (pe_erase_busy || pe_prog_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(read_mode == 2'd0, "R1 read_mode", read_mode, 0);
    chk(op_valid == 1'b0, "R1 op_valid", op_valid, 0);
  endtask

  task automatic t_program();
    int b = n_ops;
    wr(18'h00555, 8'hAA, 20);  // R12: long strobe is one write
    wr(18'h00AAA, 8'h55); wr(18'h00555, 8'hA0); wr(18'h12345, 8'h5A);
    chk(n_ops == b + 1, "R12 one request", n_ops - b, 1);
    chk(lk[b] == 3'd1, "R2 kind", lk[b], 1);
    chk(la[b] == 18'h12345, "R2 addr", la[b], 18'h12345);
    chk(ld[b] == 8'h5A, "R2 data", ld[b], 8'h5A);
    chk(read_mode == 2'd2, "R9 status while programming", read_mode, 2);
    unlock3(8'hA0); wr(18'h00077, 8'h11);   // R13: ignored while busy
    chk(n_ops == b + 1, "R13 no request while programming", n_ops - b, 1);
    wait_idle();
    chk(read_mode == 2'd0, "R2 back to array", read_mode, 0);
  endtask

  task automatic t_chip_high_bits();
    int b = n_ops;
    wr(18'h3F555, 8'hAA); wr(18'h1FAAA, 8'h55); wr(18'h2A555, 8'h80);
    wr(18'h15555, 8'hAA); wr(18'h3FAAA, 8'h55); wr(18'h3F555, 8'h10);
    chk(n_ops == b + 1, "R3 high bits ignored", n_ops - b, 1);
    chk(lk[b] == 3'd2, "R4 chip erase kind", lk[b], 2);
    wait_idle();
  endtask

  task automatic t_broken();
    int b = n_ops;
    wr(18'h00555, 8'hAA); wr(18'h00555, 8'h55); wr(18'h00555, 8'hA0); wr(18'h00100, 8'h12);
    unlock3(8'h77); wr(18'h00200, 8'h34);
    unlock3(8'h80); wr(18'h00555, 8'hAA); wr(18'h00AAA, 8'h55); wr(18'h00555, 8'h20);
    chk(n_ops == b, "R7 broken sequences give no request", n_ops - b, 0);
    chk(read_mode == 2'd0, "R7 read array", read_mode, 0);
    unlock3(8'hA0); wr(18'h00300, 8'hC3);
    chk(n_ops == b + 1 && lk[b] == 3'd1, "R7 recovery program", lk[b], 1);
    wait_idle();
  endtask

  task automatic t_ident();
    unlock3(8'h90);
    chk(read_mode == 2'd1, "R8 signature mode", read_mode, 1);
    wr(18'h00000, 8'hF0);
    chk(read_mode == 2'd0, "R8 reset write", read_mode, 0);
    unlock3(8'h90);
    wr(18'h00555, 8'hAA);
    chk(read_mode == 2'd0, "R8 any write leaves signature", read_mode, 0);
    wr(18'h00000, 8'hF0);
  endtask

  task automatic t_block();
    int b = n_ops;
    block_erase(18'h20000);
    chk(n_ops == b + 1 && lk[b] == 3'd3, "R5 block mark", lk[b], 3);
    chk(la[b] == 18'h20000, "R5 mark addr", la[b], 18'h20000);
    chk(read_mode == 2'd2, "R9 status in window", read_mode, 2);
    wait_ops(b + 2);
    chk(lk[b+1] == 3'd4, "R5 erase start", lk[b+1], 4);
    chk(lt[b+1] - lt[b] == W + 1, "R5 window length", lt[b+1] - lt[b], W + 1);
    wait_idle();
  endtask

  task automatic t_collide();
    int b = n_ops; int e;
    block_erase(18'h10000);
    e = lt[b];
    while (cyc != e + W - 2) @(negedge clk);
    wr(18'h30000, 8'h30);
    wait_ops(b + 3);
    chk(lk[b+1] == 3'd3 && la[b+1] == 18'h30000, "R6 add on final cycle", lk[b+1], 3);
    chk(lt[b+1] == e + W + 1, "R6 add time", lt[b+1] - e, W + 1);
    chk(lk[b+2] == 3'd4 && lt[b+2] == e + 2*W + 2, "R6 restarted window", lt[b+2] - e, 2*W + 2);
    wait_idle();
  endtask

  task automatic t_late();
    int b = n_ops; int e;
    block_erase(18'h10000);
    e = lt[b];
    while (cyc != e + W - 1) @(negedge clk);
    wr(18'h30000, 8'h30);
    wait_ops(b + 2);
    chk(lk[b+1] == 3'd4 && lt[b+1] == e + W + 1, "R6 expiry before late add", lt[b+1] - e, W + 1);
    wait_idle();
    chk(n_ops == b + 2, "R6 late add ignored", n_ops - b, 2);
  endtask

  task automatic t_suspend();
    int b = n_ops;
    block_erase(18'h08000);
    wait_ops(b + 2);
    unlock3(8'hA0); wr(18'h00400, 8'h66);
    chk(n_ops == b + 2, "R10 program blocked during erase", n_ops - b, 2);
    wr(18'h00000, 8'hB0);
    chk(n_ops == b + 3 && lk[b+2] == 3'd5, "R10 suspend", lk[b+2], 5);
    chk(read_mode == 2'd0, "R11 array while suspended", read_mode, 0);
    unlock3(8'hA0); wr(18'h00400, 8'h66);
    chk(n_ops == b + 4 && lk[b+3] == 3'd1, "R11 program in suspend", lk[b+3], 1);
    while (pe_prog_busy) @(negedge clk);
    unlock3(8'h80); wr(18'h00555, 8'hAA); wr(18'h00AAA, 8'h55); wr(18'h00555, 8'h10);
    chk(n_ops == b + 4, "R11 erase rejected in suspend", n_ops - b, 4);
    wr(18'h00000, 8'h30);
    chk(n_ops == b + 5 && lk[b+4] == 3'd6, "R11 resume", lk[b+4], 6);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_program();
    t_chip_high_bits();
    t_broken();
    t_ident();
    t_block();
    t_collide();
    t_late();
    t_suspend();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule